// File: doc/BRIEF.md
# Machine Check Error Signaling Unit

This block gathers the error conditions that may halt the processor and turns them into one registered, active-low machine-check line. Three kinds of source feed it. There is a vector of processor-bus error sources. There is an external machine-check request held as a level. There are the two ECC outcomes of the memory path. One enable bit, taken from an option register input, decides whether the machine-check line may assert at all.

Each source has its own rule. A bus error fires once and then sets a lock flag, and the lock masks further bus errors until software clears it. The external request is a level with no memory. It drives the line for as long as it and the enable bit are both high, and it never sets the lock. An uncorrectable ECC error starts a pulse with a guaranteed minimum length. A correctable ECC error never reaches the machine-check line and is routed to interrupt request line 0 instead.

Top module: `mce_signal_unit`

## Requirements
- R1: Out of reset, `mc_n_o` is high, `ce_irq_o` is low and the bus-error lock is clear.
- R2: While `ext_req_i` is high and the enable bit (`opt_reg_i` bit 1) is low, `mc_n_o` stays high.
- R3: When `ext_req_i` and the enable bit are both high at a clock edge, `mc_n_o` is low in the following cycle. This includes the edge at which the enable bit first becomes set while the request is already held.
- R4: The external request never sets the bus-error lock. A bus error that follows a request still produces a machine-check pulse.
- R5: Any bit of `bus_err_i` high while the lock is clear sets the lock. With the enable bit high, it also drives `mc_n_o` low for MIN_PULSE (default 2) cycles, starting in the next cycle.
- R6: While the lock is set, bus errors have no effect on `mc_n_o`. A one-cycle `lock_clr_i` pulse clears the lock, and a bus error at the next edge fires again.
- R7: A bus error that arrives while the enable bit is low still sets the lock, and `mc_n_o` stays high.
- R8: `ecc_ue_i` high at an edge with the enable bit high drives `mc_n_o` low for exactly MIN_PULSE cycles when no other source is active.
- R9: `ecc_ue_i` high with the enable bit low is ignored. It is not replayed when the enable bit is set later.
- R10: A new uncorrectable error during an active pulse restarts the count, so `mc_n_o` stays low for MIN_PULSE cycles after the last such error.
- R11: `ecc_ce_i` never drives `mc_n_o` low.
- R12: In the default level mode, `ce_irq_o` follows `ecc_ce_i` one cycle later. In pulse mode, it is high for one cycle after each rising edge of `ecc_ce_i`.
- R13: `mc_n_o` is low in a cycle exactly when either the external-request rule or the pulse rule asks for it, that is, the logical OR of the sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_err_i | input | NUM_BUS_ERR | Processor-bus error sources, one bit per source |
| ext_req_i | input | 1 | External machine-check request, level |
| ecc_ue_i | input | 1 | Uncorrectable ECC error indication |
| ecc_ce_i | input | 1 | Correctable ECC error indication |
| opt_reg_i | input | OPT_W | Option register contents; bit EN_BIT (default 1) is the machine-check enable |
| lock_clr_i | input | 1 | Software clear of the bus-error lock |
| mc_n_o | output | 1 | Machine-check output to the processor, active low, registered |
| ce_irq_o | output | 1 | Correctable-error request on interrupt line 0 |

## Verification
The overlap that matters most is an uncorrectable ECC error landing inside a pulse already running from a bus error, or while the external request holds the line low. Two pulse starts share one counter, and the request sits on top of that counter. The bench provokes this in two ways. Directed sequences fire a second trigger one cycle into a pulse, and random stimulus mixes all sources with enable toggling. A bench model built from the OR rule (R13) and the restart rule (R10) then judges every cycle's `mc_n_o`.

// File: rtl/mce_pkg.sv
package mce_pkg;

   // Selects how a correctable ECC error is presented on its request line.
   typedef enum logic [0:0] {
      CE_IRQ_LEVEL = 1'b0,
      CE_IRQ_PULSE = 1'b1
   } ce_irq_mode_e;

   // Width of a down counter that must hold the value n.
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/mce_err_lock.sv
module mce_err_lock #(
   parameter int unsigned NUM_SRC = 4
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] err_i,
   input  logic               clr_i,
   input  logic               en_i,
   output logic               lock_o,
   output logic               fire_o
);

   logic any_err;
   logic lock_q;

   generate
      if (NUM_SRC < 1) begin : g_bad_src
         $error("mce_err_lock: NUM_SRC must be at least 1");
      end
   endgenerate

   assign any_err = |err_i;

   // A fresh error only counts when no earlier one is being held.
   assign fire_o = any_err & ~lock_q & en_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lock_q <= 1'b0;
      end else begin
         lock_q <= any_err | (lock_q & ~clr_i);
      end
   end

   assign lock_o = lock_q;

endmodule

// File: rtl/mce_pulse_hold.sv
module mce_pulse_hold #(
   parameter int unsigned MIN_PULSE = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic trig_i,
   output logic hold_o
);

   localparam int unsigned CW = mce_pkg::cnt_width(MIN_PULSE);
   localparam logic [CW-1:0] RELOAD = CW'(MIN_PULSE - 1);

   logic [CW-1:0] left_q;
   logic          busy;

   generate
      if (MIN_PULSE < 1) begin : g_bad_len
         $error("mce_pulse_hold: MIN_PULSE must be at least 1");
      end
   endgenerate

   assign busy   = (left_q != '0);
   assign hold_o = trig_i | busy;

   // A trigger always reloads, so a late trigger extends the window.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         left_q <= '0;
      end else if (trig_i) begin
         left_q <= RELOAD;
      end else if (busy) begin
         left_q <= left_q - CW'(1);
      end
   end

endmodule

// File: rtl/mce_ce_route.sv
module mce_ce_route #(
   parameter mce_pkg::ce_irq_mode_e MODE = mce_pkg::CE_IRQ_LEVEL
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic ce_i,
   output logic irq_o
);

   logic irq_q;

   generate
      if (MODE == mce_pkg::CE_IRQ_PULSE) begin : g_pulse
         logic ce_d;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               ce_d  <= 1'b0;
               irq_q <= 1'b0;
            end else begin
               ce_d  <= ce_i;
               irq_q <= ce_i & ~ce_d;
            end
         end
      end else begin : g_level
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               irq_q <= 1'b0;
            end else begin
               irq_q <= ce_i;
            end
         end
      end
   endgenerate

   assign irq_o = irq_q;

endmodule

// File: rtl/mce_signal_unit.sv
module mce_signal_unit #(
   parameter int unsigned          NUM_BUS_ERR = 4,
   parameter int unsigned          OPT_W       = 8,
   parameter int unsigned          EN_BIT      = 1,
   parameter int unsigned          MIN_PULSE   = 2,
   parameter mce_pkg::ce_irq_mode_e CE_MODE    = mce_pkg::CE_IRQ_LEVEL
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic [NUM_BUS_ERR-1:0] bus_err_i,
   input  logic                   ext_req_i,
   input  logic                   ecc_ue_i,
   input  logic                   ecc_ce_i,
   input  logic [OPT_W-1:0]       opt_reg_i,
   input  logic                   lock_clr_i,
   output logic                   mc_n_o,
   output logic                   ce_irq_o
);

   logic mc_en;
   logic lock_q;
   logic bus_fire;
   logic ue_fire;
   logic pulse_hold;
   logic ext_hold;
   logic mc_n_q;

   generate
      if (EN_BIT >= OPT_W) begin : g_bad_bit
         $error("mce_signal_unit: EN_BIT lies outside the option register");
      end
   endgenerate

   assign mc_en    = opt_reg_i[EN_BIT];
   assign ue_fire  = ecc_ue_i & mc_en;
   assign ext_hold = ext_req_i & mc_en;

   mce_err_lock #(
      .NUM_SRC (NUM_BUS_ERR)
   ) u_lock (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .err_i  (bus_err_i),
      .clr_i  (lock_clr_i),
      .en_i   (mc_en),
      .lock_o (lock_q),
      .fire_o (bus_fire)
   );

   mce_pulse_hold #(
      .MIN_PULSE (MIN_PULSE)
   ) u_hold (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .trig_i (bus_fire | ue_fire),
      .hold_o (pulse_hold)
   );

   mce_ce_route #(
      .MODE (CE_MODE)
   ) u_ce (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ce_i   (ecc_ce_i),
      .irq_o  (ce_irq_o)
   );

   // Registered output: no combinational path reaches the processor pin.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mc_n_q <= 1'b1;
      end else begin
         mc_n_q <= ~(pulse_hold | ext_hold);
      end
   end

   assign mc_n_o = mc_n_q;

endmodule

// File: rtl/mce_signal_unit_chk.sv
module mce_signal_unit_chk #(
   parameter int unsigned NUM_BUS_ERR = 4,
   parameter int unsigned OPT_W       = 8,
   parameter int unsigned EN_BIT      = 1,
   parameter int unsigned MIN_PULSE   = 2
) (
   input logic                   clk_i,
   input logic                   rst_ni,
   input logic [NUM_BUS_ERR-1:0] bus_err_i,
   input logic                   ext_req_i,
   input logic                   ecc_ue_i,
   input logic                   ecc_ce_i,
   input logic [OPT_W-1:0]       opt_reg_i,
   input logic                   lock_clr_i,
   input logic                   mc_n_o,
   input logic                   lock_q
);

   localparam int unsigned CW = mce_pkg::cnt_width(MIN_PULSE);

   logic          en;
   logic [CW-1:0] ue_left;

   assign en = opt_reg_i[EN_BIT];

   // Independent window counter for the uncorrectable-error minimum.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ue_left <= '0;
      end else if (ecc_ue_i && en) begin
         ue_left <= CW'(MIN_PULSE);
      end else if (ue_left != '0) begin
         ue_left <= ue_left - CW'(1);
      end
   end

   AST_EXT_ASSERTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ext_req_i && en) |=> !mc_n_o); // R3

   AST_UE_MIN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ue_left != '0) |-> !mc_n_o); // R8

   AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en && mc_n_o && ue_left == '0 && $past(mc_n_o)) |=> mc_n_o); // R2

   AST_BUS_SETS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|bus_err_i) |=> lock_q); // R5

   AST_LOCK_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lock_q && !lock_clr_i) |=> lock_q); // R6

   AST_EXT_NO_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!lock_q && bus_err_i == '0 && ext_req_i) |=> !lock_q); // R4

   AST_CE_NO_MC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ecc_ce_i && !en && mc_n_o && $past(mc_n_o) && ue_left == '0) |=> mc_n_o); // R11

endmodule

bind mce_signal_unit mce_signal_unit_chk #(
   .NUM_BUS_ERR (NUM_BUS_ERR),
   .OPT_W       (OPT_W),
   .EN_BIT      (EN_BIT),
   .MIN_PULSE   (MIN_PULSE)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .bus_err_i  (bus_err_i),
   .ext_req_i  (ext_req_i),
   .ecc_ue_i   (ecc_ue_i),
   .ecc_ce_i   (ecc_ce_i),
   .opt_reg_i  (opt_reg_i),
   .lock_clr_i (lock_clr_i),
   .mc_n_o     (mc_n_o),
   .lock_q     (lock_q)
);

// File: tb/mce_signal_unit_tb_top.sv
`timescale 1ns/1ps
module mce_signal_unit_tb_top;

   localparam int NB   = 4;
   localparam int OW   = 8;
   localparam int MINP = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NB-1:0] bus_err = '0;
   logic          ext_req = 1'b0;
   logic          ue = 1'b0;
   logic          ce = 1'b0;
   logic [OW-1:0] opt = '0;
   logic          clr = 1'b0;
   logic          mc_n;
   logic          irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // reference state, derived from the requirements
   bit m_lock = 1'b0;
   int m_left = 0;
   bit e_mc_n = 1'b1;
   bit e_irq  = 1'b0;

   always #2 clk = ~clk;

   mce_signal_unit #(
      .NUM_BUS_ERR (NB),
      .OPT_W       (OW),
      .EN_BIT      (1),
      .MIN_PULSE   (MINP)
   ) dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .bus_err_i  (bus_err),
      .ext_req_i  (ext_req),
      .ecc_ue_i   (ue),
      .ecc_ce_i   (ce),
      .opt_reg_i  (opt),
      .lock_clr_i (clr),
      .mc_n_o     (mc_n),
      .ce_irq_o   (irq)
   );

   function automatic bit f_en();
      return opt[1];
   endfunction

   // R13: output is the OR of the request rule and the pulse rule
   function automatic void model_edge();
      bit bus_new;
      bit trig;
      bus_new = (|bus_err) && !m_lock && f_en();   // R5 R6 R7
      trig    = bus_new || (ue && f_en());          // R8 R9
      e_mc_n  = !(trig || m_left != 0 || (ext_req && f_en())); // R2 R3
      if (trig) m_left = MINP - 1;                  // R10
      else if (m_left != 0) m_left = m_left - 1;
      m_lock  = (|bus_err) || (m_lock && !clr);     // R4
      e_irq   = ce;                                 // R12 level mode
   endfunction

   task automatic chk(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(input string tag);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      chk(tag, mc_n, e_mc_n);
      chk({tag, " irq"}, irq, e_irq);
   endtask

   task automatic idle_inputs();
      bus_err = '0; ext_req = 1'b0; ue = 1'b0; ce = 1'b0; clr = 1'b0;
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      #800000;
      if (!done) begin
         n_bad++;
         $display("FAIL R1 watchdog: actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7311));
      repeat (3) @(negedge clk);
      chk("R1 reset mc_n", mc_n, 1'b1);
      chk("R1 reset irq", irq, 1'b0);
      rst_n = 1'b1;
      step("R1");

      // R5 fire and pulse length
      opt = 8'h02;
      bus_err = 4'b0001; step("R5");
      chk("R5 first low", mc_n, 1'b0);
      bus_err = '0; step("R5");
      chk("R5 second low", mc_n, 1'b0);
      step("R5"); chk("R5 released", mc_n, 1'b1);

      // R6 masked while locked, fires after clear
      bus_err = 4'b0100; step("R6");
      chk("R6 masked", mc_n, 1'b1);
      bus_err = '0; clr = 1'b1; step("R6");
      clr = 1'b0; bus_err = 4'b1000; step("R6");
      chk("R6 refire", mc_n, 1'b0);
      bus_err = '0; step("R6"); step("R6");

      // R2 request held with enable clear, R3 enable arrives
      clr = 1'b1; step("R6"); clr = 1'b0;
      opt = 8'h00; ext_req = 1'b1;
      repeat (3) step("R2");
      chk("R2 quiet", mc_n, 1'b1);
      opt = 8'h02; step("R3");
      chk("R3 asserts", mc_n, 1'b0);

      // R4 request did not lock: bus error still fires
      ext_req = 1'b0; bus_err = 4'b0010; step("R4");
      chk("R4 fires", mc_n, 1'b0);
      bus_err = '0; step("R4"); step("R4");
      chk("R4 released", mc_n, 1'b1);

      // R7 disabled bus error still locks
      clr = 1'b1; step("R7"); clr = 1'b0;
      opt = 8'h00; bus_err = 4'b0001; step("R7");
      opt = 8'h02; bus_err = 4'b0001; step("R7");
      chk("R7 locked", mc_n, 1'b1);
      bus_err = '0; clr = 1'b1; step("R7"); clr = 1'b0;

      // R8 exact minimum length
      begin
         int lows = 0;
         ue = 1'b1; step("R8"); ue = 1'b0;
         if (mc_n == 1'b0) lows++;
         for (int i = 0; i < 4; i++) begin
            step("R8");
            if (mc_n == 1'b0) lows++;
         end
         n_chk++;
         if (lows != MINP) begin
            n_bad++;
            $display("FAIL R8 pulse cycles: actual=%0d expected=%0d", lows, MINP);
         end
      end

      // R9 no replay
      opt = 8'h00; ue = 1'b1; step("R9");
      ue = 1'b0; opt = 8'h02; step("R9"); step("R9");
      chk("R9 no replay", mc_n, 1'b1);

      // R10 restart during pulse, R13 overlap with bus error
      ue = 1'b1; step("R10"); ue = 1'b0; step("R10");
      ue = 1'b1; bus_err = 4'b0100; step("R13"); ue = 1'b0; bus_err = '0;
      step("R10"); chk("R10 extended", mc_n, 1'b0);
      step("R10"); chk("R10 released", mc_n, 1'b1);
      clr = 1'b1; step("R10"); clr = 1'b0;

      // R11 and R12
      ce = 1'b1; step("R11");
      chk("R11 mc high", mc_n, 1'b1);
      chk("R12 irq level", irq, 1'b1);
      step("R12");
      ce = 1'b0; step("R12");
      chk("R12 irq drop", irq, 1'b0);

      // R13 random mix
      idle_inputs();
      for (int k = 0; k < 3000; k++) begin
         bus_err = (($urandom % 10) == 0) ? NB'($urandom) : '0;
         ext_req = (($urandom % 6) == 0);
         ue      = (($urandom % 8) == 0);
         ce      = (($urandom % 4) == 0);
         clr     = (($urandom % 7) == 0);
         if (($urandom % 20) == 0) opt = OW'($urandom);
         step("R13");
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule